// File: doc/BRIEF.md
# Flash Command Bus Front End

This block is a clocked model of the bus side of a byte-wide NOR flash device. Its inputs are three active-low strobes (chip select, write strobe, output enable), an address and a write-data byte. These inputs are asynchronous to the fast system clock that runs the block. Each strobe passes through a two-flop synchroniser and a glitch filter. The filtered strobes then frame bus cycles into reads, standby, output disable and writes. A write cycle takes its address when the cycle opens and its data when the cycle closes. The closed write goes to a command sequencer.

The sequencer recognises unlock-framed program, sector erase and whole-array erase commands and hands each one to a small shadow array. That array stands in for the cell storage. It holds one byte lane, with a few bytes per sector. An operation keeps the array busy for a set number of clock cycles. While the array is busy, reads return a status byte instead of array data. The block powers up in read mode, so reads return array contents without any command first.

Top module: `flash_cmd_front`

## Requirements
- R1: A write is accepted only while the filtered chip select and write strobe are both low and output enable is high. A strobe sequence made while output enable is low commits nothing.
- R2: The command address is captured when the write cycle opens, that is, on the later of the chip-select and write-strobe falling edges. The data byte is captured when the cycle closes, on the earlier of their rising edges.
- R3: A strobe level that lasts less than two clock cycles is ignored and never frames a bus cycle.
- R4: After reset the block is in read mode. The array reads as FFh, busy is 0, the bus is not driven and sector_sel is 0. A read then returns array data with no command issued first.
- R5: dq_oe is 1 only while chip select is low, output enable is low and the write strobe is high. With output enable high the bus is not driven.
- R6: With chip select high the bus is not driven, whatever output enable does.
- R7: The program command is four writes: 555h/AAh, 2AAh/55h, 555h/A0h, then target/byte. It leaves (old AND byte) at the target. Command addresses compare only address bits 10:0. Other array locations keep their value.
- R8: sector_sel shows address bits 18:16 of the last captured write address. The sector erase command is 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, then any address in the sector with 30h. It sets only that sector to FFh. Replacing the last write with 555h/10h erases the whole array.
- R9: Each operation holds busy high for exactly BUSY_CYCLES clocks. A read during that time drives {~E7, 7'b0}, where E7 is bit 7 of the expected final data: the programmed byte for a program and 1 for an erase. The changed contents appear when busy drops.
- R10: Raising chip select while busy neither stops nor shortens the operation.
- R11: A write of F0h, or any write that does not fit the sequence in progress, returns the sequencer to read mode. No command write changes array contents unless it completes a program or erase sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Byte address |
| data_in | input | 8 | Write data |
| dq_out | output | 8 | Read data or status byte |
| dq_oe | output | 1 | High when dq_out must be driven onto the bus |
| busy | output | 1 | Program or erase in progress |
| sector_sel | output | 3 | Sector of the last captured write address |

## Verification
The bench builds the block with ADDR_W=19, LOW_W=4 and BUSY_CYCLES=40. These values give eight sectors of sixteen shadow bytes each, so a sector erase can be shown to leave a neighbouring sector alone. The 40-cycle busy window is long enough to complete a full write and a full read inside it, so the status byte can be seen at the pins. It is also long enough to hold chip select high across most of an operation and then check that the result still arrives. Short strobe pulses and skewed strobe edges, made one clock at a time, reach the glitch filter and the edge-capture rules.

// File: rtl/flash_fe_pkg.sv
// Package: shared constants and types for the flash command front end.
// Assumes: byte-wide lane, command addresses compared on bits 10:0.
package flash_fe_pkg;

    localparam int SECT_BITS = 3;
    localparam int KEY_W     = 11;

    localparam logic [KEY_W-1:0] KEY_ADDR_A = 11'h555;
    localparam logic [KEY_W-1:0] KEY_ADDR_B = 11'h2AA;

    localparam logic [7:0] KEY_DATA_A = 8'hAA;
    localparam logic [7:0] KEY_DATA_B = 8'h55;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_ERASE  = 8'h80;
    localparam logic [7:0] CMD_CHIP   = 8'h10;
    localparam logic [7:0] CMD_SECT   = 8'h30;
    localparam logic [7:0] CMD_RESET  = 8'hF0;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UNLK1,
        SQ_UNLK2,
        SQ_PROG,
        SQ_ERS1,
        SQ_ERS2,
        SQ_ERS3
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PROG,
        OP_SECT,
        OP_CHIP
    } op_kind_t;

endpackage

// File: rtl/strobe_filter.sv
// Module: strobe_filter
// Synchronises N active-low strobes with two flops each. A filtered level
// changes only after the synchronised value has held for two clocks.
// Assumes: strobes idle high; reset drives filtered outputs high.
module strobe_filter #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_n,
    output logic [N-1:0] filt_n
);

    for (genvar g = 0; g < N; g++) begin : g_lane
        logic meta_q, sync_q, prev_q, keep_q;

        // Two-flop synchroniser, one history flop, then the stability filter.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                sync_q <= 1'b1;
                prev_q <= 1'b1;
                keep_q <= 1'b1;
            end else begin
                meta_q <= raw_n[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
                if (sync_q == prev_q) begin
                    keep_q <= sync_q;
                end
            end
        end

        assign filt_n[g] = keep_q;
    end

endmodule

// File: rtl/cmd_seq.sv
// Module: cmd_seq
// Walks the unlock-framed command sequences and issues one operation
// request per completed sequence. Writes arriving while busy are dropped.
// Assumes: cmd_valid is a single-cycle pulse per completed write cycle.
module cmd_seq
    import flash_fe_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              busy,
    output logic              op_start,
    output op_kind_t          op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data
);

    seq_state_t       state_q;
    logic [KEY_W-1:0] key;
    logic             is_a, is_b;

    assign key  = cmd_addr[KEY_W-1:0];
    assign is_a = (key == KEY_ADDR_A);
    assign is_b = (key == KEY_ADDR_B);

    // Sequence state and one-cycle operation request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SQ_IDLE;
            op_start <= 1'b0;
            op_kind  <= OP_NONE;
            op_addr  <= '0;
            op_data  <= '0;
        end else begin
            op_start <= 1'b0;
            if (cmd_valid && !busy) begin
                state_q <= SQ_IDLE;
                if (cmd_data != CMD_RESET) begin
                    unique case (state_q)
                        SQ_IDLE:  if (is_a && cmd_data == KEY_DATA_A) state_q <= SQ_UNLK1;
                        SQ_UNLK1: if (is_b && cmd_data == KEY_DATA_B) state_q <= SQ_UNLK2;
                        SQ_UNLK2: begin
                            if (is_a && cmd_data == CMD_PROG)  state_q <= SQ_PROG;
                            if (is_a && cmd_data == CMD_ERASE) state_q <= SQ_ERS1;
                        end
                        SQ_PROG: begin
                            op_start <= 1'b1;
                            op_kind  <= OP_PROG;
                            op_addr  <= cmd_addr;
                            op_data  <= cmd_data;
                        end
                        SQ_ERS1:  if (is_a && cmd_data == KEY_DATA_A) state_q <= SQ_ERS2;
                        SQ_ERS2:  if (is_b && cmd_data == KEY_DATA_B) state_q <= SQ_ERS3;
                        SQ_ERS3: begin
                            if (is_a && cmd_data == CMD_CHIP) begin
                                op_start <= 1'b1;
                                op_kind  <= OP_CHIP;
                                op_addr  <= cmd_addr;
                                op_data  <= 8'hFF;
                            end else if (cmd_data == CMD_SECT) begin
                                op_start <= 1'b1;
                                op_kind  <= OP_SECT;
                                op_addr  <= cmd_addr;
                                op_data  <= 8'hFF;
                            end
                        end
                        default: state_q <= SQ_IDLE;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/flash_store.sv
// Module: flash_store
// Shadow array of (8 sectors x 2^LOW_W) bytes with a busy counter.
// Program ANDs the byte in; erase fills a sector or all with FFh. The
// change lands in the last busy cycle.
// Assumes: address bits between LOW_W and the sector field alias.
module flash_store
    import flash_fe_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int LOW_W       = 4,
    parameter int BUSY_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  op_kind_t          op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        op_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic [7:0]        status
);

    localparam int IDX_W    = SECT_BITS + LOW_W;
    localparam int DEPTH    = 1 << IDX_W;
    localparam int PER_SECT = 1 << LOW_W;
    localparam int CNT_W    = $clog2(BUSY_CYCLES + 1);

    logic [7:0]        mem [DEPTH];
    logic              busy_q;
    logic [CNT_W-1:0]  cnt_q;
    op_kind_t          kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic [IDX_W-1:0]  wr_idx;

    function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1 -: SECT_BITS], a[LOW_W-1:0]};
    endfunction

    assign wr_idx = idx_of(addr_q);

    // Operation timing and array update at the end of the busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
            busy_q <= 1'b0;
            cnt_q  <= '0;
            kind_q <= OP_NONE;
            addr_q <= '0;
            data_q <= '0;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
                case (kind_q)
                    OP_PROG: mem[wr_idx] <= mem[wr_idx] & data_q;
                    OP_SECT: for (int j = 0; j < PER_SECT; j++)
                                 mem[{addr_q[ADDR_W-1 -: SECT_BITS], LOW_W'(j)}] <= 8'hFF;
                    OP_CHIP: for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
                    default: ;
                endcase
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (op_start) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(BUSY_CYCLES - 1);
            kind_q <= op_kind;
            addr_q <= op_addr;
            data_q <= op_data;
        end
    end

    // Status byte: bit 7 is the complement of the expected final bit 7.
    always_comb begin
        status    = 8'h00;
        status[7] = (kind_q == OP_PROG) ? ~data_q[7] : 1'b0;
    end

    assign rd_data = mem[idx_of(rd_addr)];
    assign busy    = busy_q;

endmodule

// File: rtl/flash_cmd_front.sv
// Module: flash_cmd_front (top)
// Filters the strobes, frames bus cycles, latches the command address at
// write-cycle open and the data at write-cycle close, and drives read
// data or status.
// Assumes: addr and data_in are steady for a few clocks around strobe edges.
module flash_cmd_front
    import flash_fe_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int LOW_W       = 4,
    parameter int BUSY_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data_in,
    output logic [7:0]        dq_out,
    output logic              dq_oe,
    output logic              busy,
    output logic [2:0]        sector_sel
);

    logic [2:0]        filt_n;
    logic              ce_f, we_f, oe_f;
    logic              wr_act, wr_act_q;
    logic [ADDR_W-1:0] addr_lat;
    logic [7:0]        data_lat;
    logic              cmd_valid;
    logic              op_start;
    op_kind_t          op_kind;
    logic [ADDR_W-1:0] op_addr;
    logic [7:0]        op_data;
    logic [7:0]        rd_data, status;

    strobe_filter #(.N(3)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_n  ({oe_n, we_n, ce_n}),
        .filt_n (filt_n)
    );

    assign ce_f   = filt_n[0];
    assign we_f   = filt_n[1];
    assign oe_f   = filt_n[2];
    assign wr_act = !ce_f && !we_f && oe_f;

    // Write-cycle framing: address at open, data and commit at close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_act_q  <= 1'b0;
            addr_lat  <= '0;
            data_lat  <= '0;
            cmd_valid <= 1'b0;
        end else begin
            wr_act_q  <= wr_act;
            cmd_valid <= wr_act_q && !wr_act;
            if (wr_act && !wr_act_q) addr_lat <= addr;
            if (wr_act_q && !wr_act) data_lat <= data_in;
        end
    end

    cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_addr  (addr_lat),
        .cmd_data  (data_lat),
        .busy      (busy),
        .op_start  (op_start),
        .op_kind   (op_kind),
        .op_addr   (op_addr),
        .op_data   (op_data)
    );

    flash_store #(
        .ADDR_W      (ADDR_W),
        .LOW_W       (LOW_W),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_start (op_start),
        .op_kind  (op_kind),
        .op_addr  (op_addr),
        .op_data  (op_data),
        .rd_addr  (addr),
        .rd_data  (rd_data),
        .busy     (busy),
        .status   (status)
    );

    assign dq_oe      = !ce_f && !oe_f && we_f;
    assign dq_out     = busy ? status : rd_data;
    assign sector_sel = addr_lat[ADDR_W-1 -: SECT_BITS];

endmodule

// File: rtl/flash_cmd_front_chk.sv
// Module: flash_cmd_front_chk
// Checker bound to flash_cmd_front: bus release and busy-window rules,
// seen from the ports.
module flash_cmd_front_chk #(
    parameter int BUSY_CYCLES = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       we_n,
    input logic       oe_n,
    input logic       dq_oe,
    input logic [7:0] dq_out,
    input logic       busy
);

    localparam int RUN_W = $clog2(BUSY_CYCLES + 2);

    logic [2:0]       ce_hi, oe_hi, we_lo;
    logic [RUN_W-1:0] run;

    // Saturating counts of raw strobe levels and length of the busy run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_hi <= '0;
            oe_hi <= '0;
            we_lo <= '0;
            run   <= '0;
        end else begin
            ce_hi <= ce_n  ? (ce_hi == 3'd7 ? ce_hi : ce_hi + 1'b1) : 3'd0;
            oe_hi <= oe_n  ? (oe_hi == 3'd7 ? oe_hi : oe_hi + 1'b1) : 3'd0;
            we_lo <= !we_n ? (we_lo == 3'd7 ? we_lo : we_lo + 1'b1) : 3'd0;
            run   <= busy  ? run + 1'b1 : '0;
        end
    end

    assert_standby_hiz_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_hi >= 3'd6) |-> !dq_oe);

    assert_oe_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_hi >= 3'd6) |-> !dq_oe);

    assert_no_drive_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_lo >= 3'd6) |-> !dq_oe);

    assert_busy_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run < RUN_W'(BUSY_CYCLES)));

    assert_busy_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run == RUN_W'(BUSY_CYCLES)));

    assert_busy_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run < RUN_W'(BUSY_CYCLES - 1)) |=> busy);

    assert_status_low_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dq_oe) |-> (dq_out[6:0] == 7'd0));

endmodule

bind flash_cmd_front flash_cmd_front_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .we_n   (we_n),
    .oe_n   (oe_n),
    .dq_oe  (dq_oe),
    .dq_out (dq_out),
    .busy   (busy)
);

// File: tb/tb_flash_cmd_front.sv
module tb_flash_cmd_front;

    localparam int ADDR_W = 19;
    localparam int LOW_W  = 4;
    localparam int BUSY   = 40;

    localparam logic [1:0] K_W = 2'd0, K_R = 2'd1, K_B = 2'd2;
    localparam int NV = 32;
    // entry = {kind, requirement, address, write data or expected read}
    localparam logic [32:0] VEC [NV] = '{
        {K_R, 4'd4,  19'h20005, 8'hFF},  // R4 erased after reset
        {K_W, 4'd7,  19'h00555, 8'hAA},  // R7 program sequence
        {K_W, 4'd7,  19'h002AA, 8'h55},
        {K_W, 4'd7,  19'h00555, 8'hA0},
        {K_W, 4'd7,  19'h20005, 8'h3C},
        {K_R, 4'd9,  19'h00000, 8'h80},  // R9 status, expected bit7 0
        {K_B, 4'd9,  19'h00000, 8'h00},
        {K_R, 4'd7,  19'h20005, 8'h3C},
        {K_R, 4'd7,  19'h20006, 8'hFF},
        {K_W, 4'd7,  19'h00555, 8'hAA},
        {K_W, 4'd7,  19'h002AA, 8'h55},
        {K_W, 4'd7,  19'h00555, 8'hA0},
        {K_W, 4'd7,  19'h20005, 8'h8F},
        {K_R, 4'd9,  19'h20005, 8'h00},  // R9 status, expected bit7 1
        {K_B, 4'd9,  19'h00000, 8'h00},
        {K_R, 4'd7,  19'h20005, 8'h0C},  // R7 AND of 3C and 8F
        {K_W, 4'd7,  19'h00555, 8'hAA},
        {K_W, 4'd7,  19'h002AA, 8'h55},
        {K_W, 4'd7,  19'h00555, 8'hA0},
        {K_W, 4'd7,  19'h30001, 8'h55},
        {K_B, 4'd9,  19'h00000, 8'h00},
        {K_R, 4'd7,  19'h30001, 8'h55},
        {K_W, 4'd8,  19'h00555, 8'hAA},  // R8 sector erase of sector 2
        {K_W, 4'd8,  19'h002AA, 8'h55},
        {K_W, 4'd8,  19'h00555, 8'h80},
        {K_W, 4'd8,  19'h00555, 8'hAA},
        {K_W, 4'd8,  19'h002AA, 8'h55},
        {K_W, 4'd8,  19'h20000, 8'h30},
        {K_R, 4'd9,  19'h00000, 8'h00},  // R9 erase status
        {K_B, 4'd9,  19'h00000, 8'h00},
        {K_R, 4'd8,  19'h20005, 8'hFF},
        {K_R, 4'd8,  19'h30001, 8'h55}   // R8 other sector kept
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              ce_n, we_n, oe_n;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        data_in;
    logic [7:0]        dq_out;
    logic              dq_oe, busy;
    logic [2:0]        sector_sel;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;

    flash_cmd_front #(.ADDR_W(ADDR_W), .LOW_W(LOW_W), .BUSY_CYCLES(BUSY)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .data_in(data_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .busy(busy), .sector_sel(sector_sel)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        addr = a; data_in = d; oe_n = 1'b1;
        ce_n = 1'b0; idle(1);
        we_n = 1'b0; idle(6);
        we_n = 1'b1; idle(1);
        ce_n = 1'b1; idle(6);
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [7:0] d, output logic oe);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; idle(8);
        d = dq_out; oe = dq_oe;
        ce_n = 1'b1; oe_n = 1'b1; idle(6);
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (busy && n < 1000) begin idle(1); n++; end
        check(!busy, req, busy, 0);
    endtask

    task automatic unlock_prog();
        bus_write(19'h00555, 8'hAA);
        bus_write(19'h002AA, 8'h55);
        bus_write(19'h00555, 8'hA0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic       roe;
        rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        addr = '0; data_in = '0;
        idle(5);
        rst_n = 1'b1;
        idle(2);

        // R4 reset state
        check(!dq_oe && !busy && sector_sel == 3'd0, "R4", {dq_oe, busy, sector_sel}, 0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            logic [1:0]        k = VEC[i][32:31];
            string             rq = $sformatf("R%0d vec%0d", VEC[i][30:27], i);
            logic [ADDR_W-1:0] va = VEC[i][26:8];
            logic [7:0]        vd = VEC[i][7:0];
            if (k == K_W) bus_write(va, vd);
            else if (k == K_B) wait_idle(rq);
            else begin
                bus_read(va, rd, roe);
                check(roe && rd == vd, rq, rd, vd);
            end
        end

        // R5 output disable, then a normal read drive
        addr = 19'h20005; ce_n = 1'b0; oe_n = 1'b1; idle(8);
        check(!dq_oe, "R5 oe high", dq_oe, 0);
        oe_n = 1'b0; idle(8);
        check(dq_oe, "R5 read drives", dq_oe, 1);
        // R6 standby with output enable low
        ce_n = 1'b1; idle(8);
        check(!dq_oe, "R6 standby", dq_oe, 0);
        oe_n = 1'b1; idle(4);

        // R8 sector_sel from A18..A16 of the captured address
        bus_write(19'h58000, 8'hF0);
        check(sector_sel == 3'd5, "R8 sector_sel", sector_sel, 5);

        // R11 F0 aborts a partial sequence
        bus_write(19'h00555, 8'hAA);
        bus_write(19'h002AA, 8'h55);
        bus_write(19'h00555, 8'hF0);
        bus_write(19'h00555, 8'hA0);
        bus_write(19'h20007, 8'h00);
        idle(4);
        check(!busy, "R11 abort no op", busy, 0);
        bus_read(19'h20007, rd, roe);
        check(rd == 8'hFF, "R11 abort array", rd, 8'hFF);

        // R11 mismatched write aborts
        bus_write(19'h00555, 8'hAA);
        bus_write(19'h00555, 8'h55);
        bus_write(19'h00555, 8'hA0);
        bus_write(19'h20007, 8'h00);
        bus_read(19'h20007, rd, roe);
        check(rd == 8'hFF && !busy, "R11 mismatch", rd, 8'hFF);

        // R3 one-clock write strobe is ignored
        unlock_prog();
        addr = 19'h20007; data_in = 8'h00;
        ce_n = 1'b0; idle(2);
        we_n = 1'b0; idle(1);
        we_n = 1'b1; idle(4);
        ce_n = 1'b1; idle(8);
        check(!busy, "R3 glitch busy", busy, 0);
        bus_read(19'h20007, rd, roe);
        check(rd == 8'hFF, "R3 glitch array", rd, 8'hFF);
        bus_write(19'h00555, 8'hF0);

        // R1 strobes with output enable low commit nothing
        unlock_prog();
        addr = 19'h20007; data_in = 8'h00; oe_n = 1'b0;
        ce_n = 1'b0; idle(1);
        we_n = 1'b0; idle(6);
        we_n = 1'b1; idle(1);
        ce_n = 1'b1; oe_n = 1'b1; idle(8);
        check(!busy, "R1 oe low busy", busy, 0);
        bus_read(19'h20007, rd, roe);
        check(rd == 8'hFF, "R1 oe low array", rd, 8'hFF);
        bus_write(19'h00555, 8'hF0);

        // R2 later falling edge takes address, earlier rising takes data
        unlock_prog();
        addr = 19'h00003; data_in = 8'h00; oe_n = 1'b1;
        we_n = 1'b0; idle(6);
        addr = 19'h40003; data_in = 8'h5A;
        ce_n = 1'b0; idle(6);
        ce_n = 1'b1; idle(6);
        addr = 19'h00003; data_in = 8'h00; idle(2);
        we_n = 1'b1; idle(6);
        wait_idle("R2 wait");
        bus_read(19'h40003, rd, roe);
        check(rd == 8'h5A, "R2 captured", rd, 8'h5A);
        bus_read(19'h00003, rd, roe);
        check(rd == 8'hFF, "R2 not at early address", rd, 8'hFF);

        // R10 chip select high throughout busy
        unlock_prog();
        bus_write(19'h50001, 8'hA5);
        idle(10);
        check(busy, "R10 early", busy, 1);
        idle(22);
        check(busy, "R10 late", busy, 1);
        wait_idle("R10 wait");
        bus_read(19'h50001, rd, roe);
        check(rd == 8'hA5, "R10 result", rd, 8'hA5);

        // R8 whole-array erase, R9 busy length
        bus_write(19'h00555, 8'hAA);
        bus_write(19'h002AA, 8'h55);
        bus_write(19'h00555, 8'h80);
        bus_write(19'h00555, 8'hAA);
        bus_write(19'h002AA, 8'h55);
        addr = 19'h00555; data_in = 8'h10; oe_n = 1'b1;
        ce_n = 1'b0; idle(1);
        we_n = 1'b0; idle(6);
        we_n = 1'b1; idle(1);
        ce_n = 1'b1;
        begin
            int hi = 0;
            for (int c = 0; c < 200; c++) begin
                idle(1);
                if (busy) hi++;
            end
            check(hi == BUSY, "R9 busy length", hi, BUSY);
        end
        bus_read(19'h30001, rd, roe);
        check(rd == 8'hFF, "R8 chip erase a", rd, 8'hFF);
        bus_read(19'h50001, rd, roe);
        check(rd == 8'hFF, "R8 chip erase b", rd, 8'hFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule